// File: doc/BRIEF.md
# Mapped-Window Serial Flash Read Engine

This block turns word reads into a 64 MiB address window into read frames on a single-lane serial flash bus. Each read is looked up in a one-line read cache. A hit answers one cycle after the request is accepted and starts no flash activity. A miss opens one chip-select frame. The frame carries an optional command byte, an optional option byte, a 3- or 4-byte address and a programmable number of dummy clocks. It then reads back a burst of 32-bit words, which is stored in the line.

The flash address is built from the window offset and a separate 4-bit upper-address value placed above the window. The number of bytes to read is not taken from any enable mask. Every access is one 32-bit word, and byte-offset bits are ignored. A flush input invalidates the whole line. It must be pulsed after any change to the extended address, the command setup or the bus arrangement. A mode input parks the mapped path so that another transfer engine can own the bus.

Top module: `xip_read_engine`

## Requirements
- R1: After reset, `flash_cs_n` is high, `flash_sclk` is low, `rsp_valid` is low, and `req_ready` is high while `cfg_mode` is 0.
- R2: A frame sends, most significant bit first on `flash_mosi`, these fields in this order:
  - the command byte `cfg_cmd`, if `cfg_cmd_en` is set;
  - then `cfg_opt`, if `cfg_opt_en` is set;
  - then the flash address: 4 bytes when `cfg_addr_code` is 3 or more, otherwise its low 3 bytes;
  - then `cfg_dummy` idle clocks.

  The flash address is {2'b00, cfg_ext, req_addr[25:2], 2'b00}.
- R3: Data is sampled from `flash_miso` most significant bit first. The first byte received lands in `rsp_data[7:0]` and the fourth in `rsp_data[31:24]`.
- R4: A miss at word index i of its 8-word line opens exactly one frame. That frame reads min(N, 8 - i) words starting at word i, where N = `cfg_burst_m1` + 1 when `cfg_burst_en` is 1, and N = 1 otherwise.
- R5: A read of a word held in the line opens no frame and raises `rsp_valid` in the cycle right after acceptance.
- R6: From the acceptance of a miss until its response, `req_ready` is low.
- R7: A `cfg_flush` pulse invalidates every cached word, including when it arrives during a fill. The next read of any word then opens a frame.
- R8: While `cfg_mode` is 1, `req_ready` stays low, no request is accepted and no frame starts.
- R9: `req_addr[1:0]` does not affect the data returned or the flash address.
- R10: `rsp_valid` is high for exactly one cycle per accepted request.
- R11: `flash_cs_n` stays low for the whole of a frame. `flash_sclk` toggles only while `flash_cs_n` is low.
- R12: `cfg_ext` appears as flash address bits 29:26 in 4-byte address mode. Data read with different `cfg_ext` values comes from the matching flash locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | 0: mapped read path active, 1: path parked |
| cfg_flush | input | 1 | Pulse to invalidate the read line |
| cfg_cmd | input | 8 | Command byte |
| cfg_cmd_en | input | 1 | Send command byte |
| cfg_opt | input | 8 | Option byte |
| cfg_opt_en | input | 1 | Send option byte |
| cfg_addr_code | input | 3 | Address size code (3 or more: 4 bytes, else 3 bytes) |
| cfg_dummy | input | 5 | Dummy clock count |
| cfg_ext | input | 4 | Upper flash address bits above the window |
| cfg_burst_m1 | input | 5 | Burst length minus one, in words |
| cfg_burst_en | input | 1 | Use the programmed burst length |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted this cycle |
| req_addr | input | 26 | Byte offset into the window |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | 32 | Read data word |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sclk | output | 1 | Flash serial clock |
| flash_mosi | output | 1 | Serial data to flash |
| flash_miso | input | 1 | Serial data from flash |

## Verification
The main stimulus is a sweep over five burst lengths (1, 2, 4, 8 and the 32-word maximum) and all eight start positions in a line. The sweep uses 4-byte addressing, an option byte, and dummy counts that differ per burst setting. For each point, the bench reads the first word and then the words the burst should have filled, which must not open a frame. It then reads the first word past the burst, which must open one. This separates the burst clamp at the line end from the burst field itself. Every word is compared against a flash model keyed on the received address, with the extended-address value changing per point. A wrong address byte, field order or byte lane therefore shows up as a data mismatch. Shorter runs cover the default 3-byte setup, byte-offset aliasing, a flush issued mid-fill, burst disable and the parked mode.

// File: rtl/xip_pkg.sv
package xip_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_OPT,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_END
    } phase_e;

    typedef enum logic {
        CT_IDLE,
        CT_FILL
    } ctl_e;

endpackage

// File: rtl/xip_serial_seq.sv
module xip_serial_seq
    import xip_pkg::*;
#(
    parameter int WCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [7:0]     cmd,
    input  logic           cmd_en,
    input  logic [7:0]     opt,
    input  logic           opt_en,
    input  logic           addr4,
    input  logic [4:0]     dummy,
    input  logic [31:0]    faddr,
    input  logic [WCW-1:0] n_words,
    output logic           cs_n,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic           word_valid,
    output logic [31:0]    word_data,
    output logic           done
);

    typedef struct packed {
        phase_e         ph;
        logic           half;
        logic [5:0]     cnt;
        logic [31:0]    sh_out;
        logic [31:0]    sh_in;
        logic [WCW-1:0] left;
        logic [7:0]     opt;
        logic           opt_en;
        logic           addr4;
        logic [4:0]     dummy;
        logic [31:0]    faddr;
    } seq_t;

    seq_t q, d;

    // Move to phase p, skipping phases that are switched off, and load its shifter.
    function automatic seq_t enter(seq_t s, phase_e p);
        seq_t   r;
        phase_e t;
        r = s;
        t = p;
        if (t == PH_OPT && !s.opt_en)
            t = PH_ADDR;
        if (t == PH_DUMMY && s.dummy == 5'd0)
            t = PH_DATA;
        r.ph   = t;
        r.half = 1'b0;
        case (t)
            PH_OPT: begin
                r.sh_out = {s.opt, 24'd0};
                r.cnt    = 6'd8;
            end
            PH_ADDR: begin
                if (s.addr4) begin
                    r.sh_out = s.faddr;
                    r.cnt    = 6'd32;
                end else begin
                    r.sh_out = {s.faddr[23:0], 8'd0};
                    r.cnt    = 6'd24;
                end
            end
            PH_DUMMY: begin
                r.sh_out = '0;
                r.cnt    = {1'b0, s.dummy};
            end
            default: begin
                r.sh_out = '0;
                r.cnt    = 6'd32;
            end
        endcase
        return r;
    endfunction

    always_comb begin
        d          = q;
        word_valid = 1'b0;
        word_data  = '0;
        done       = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.left   = n_words;
                    d.opt    = opt;
                    d.opt_en = opt_en;
                    d.addr4  = addr4;
                    d.dummy  = dummy;
                    d.faddr  = faddr;
                    d.sh_in  = '0;
                    if (cmd_en) begin
                        d.ph     = PH_CMD;
                        d.half   = 1'b0;
                        d.sh_out = {cmd, 24'd0};
                        d.cnt    = 6'd8;
                    end else begin
                        d = enter(d, PH_OPT);
                    end
                end
            end
            PH_END: begin
                d.ph = PH_IDLE;
                done = 1'b1;
            end
            default: begin
                if (!q.half) begin
                    d.half = 1'b1;
                end else begin
                    d.half   = 1'b0;
                    d.sh_in  = {q.sh_in[30:0], miso};
                    d.sh_out = {q.sh_out[30:0], 1'b0};
                    d.cnt    = q.cnt - 6'd1;
                    if (q.cnt == 6'd1) begin
                        case (q.ph)
                            PH_CMD:   d = enter(d, PH_OPT);
                            PH_OPT:   d = enter(d, PH_ADDR);
                            PH_ADDR:  d = enter(d, PH_DUMMY);
                            PH_DUMMY: d = enter(d, PH_DATA);
                            default: begin
                                word_valid = 1'b1;
                                word_data  = {d.sh_in[7:0], d.sh_in[15:8],
                                              d.sh_in[23:16], d.sh_in[31:24]};
                                d.left     = q.left - 1'b1;
                                if (q.left == WCW'(1))
                                    d.ph = PH_END;
                                else
                                    d.cnt = 6'd32;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cs_n = (q.ph == PH_IDLE) || (q.ph == PH_END);
    assign sclk = !cs_n && q.half;
    assign mosi = !cs_n && q.sh_out[31];

endmodule

// File: rtl/xip_line_cache.sv
module xip_line_cache #(
    parameter int LINE_WORDS = 8,
    parameter int TAG_W      = 21,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             retag,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             hit,
    output logic [31:0]      rd_data
);

    typedef struct packed {
        logic [TAG_W-1:0]      tag;
        logic [LINE_WORDS-1:0] valid;
    } line_t;

    line_t q, d;
    logic [31:0] mem_q [LINE_WORDS];

    always_comb begin
        d = q;
        if (flush) begin
            d.valid = '0;
        end else if (retag && new_tag != q.tag) begin
            d.valid = '0;
            d.tag   = new_tag;
        end
        if (wr_en)
            d.valid[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(w))
                mem_q[w] <= wr_data;
        end
    end

    assign hit     = q.valid[rd_idx] && (q.tag == rd_tag);
    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/xip_read_engine.sv
module xip_read_engine
    import xip_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int WIN_W      = 26,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int TAG_W     = WIN_W - 2 - IDX_W,
    localparam int CNT_W     = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_flush,
    input  logic [7:0]       cfg_cmd,
    input  logic             cfg_cmd_en,
    input  logic [7:0]       cfg_opt,
    input  logic             cfg_opt_en,
    input  logic [2:0]       cfg_addr_code,
    input  logic [4:0]       cfg_dummy,
    input  logic [3:0]       cfg_ext,
    input  logic [4:0]       cfg_burst_m1,
    input  logic             cfg_burst_en,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [WIN_W-1:0] req_addr,
    output logic             rsp_valid,
    output logic [31:0]      rsp_data,
    output logic             flash_cs_n,
    output logic             flash_sclk,
    output logic             flash_mosi,
    input  logic             flash_miso
);

    typedef struct packed {
        ctl_e             st;
        logic [IDX_W-1:0] want;
        logic [IDX_W-1:0] widx;
        logic             pend;
        logic             rsp_v;
        logic [31:0]      rsp_d;
    } ctl_t;

    ctl_t q, d;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic [5:0]       burst;
    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] n_words;
    logic [31:0]      faddr;
    logic             seq_start, seq_done, word_valid;
    logic [31:0]      word_data;
    logic             c_flush, c_retag, c_hit;
    logic [31:0]      c_rd_data;
    logic             unused_lsb;

    assign req_tag    = req_addr[WIN_W-1:2+IDX_W];
    assign req_idx    = req_addr[2+IDX_W-1:2];
    assign unused_lsb = ^req_addr[1:0];
    assign burst      = cfg_burst_en ? (6'(cfg_burst_m1) + 6'd1) : 6'd1;
    assign room       = CNT_W'(LINE_WORDS) - CNT_W'(req_idx);
    assign n_words    = (7'(burst) < 7'(room)) ? CNT_W'(burst) : room;
    assign faddr      = {2'b00, cfg_ext, req_addr[WIN_W-1:2], 2'b00};
    assign req_ready  = (q.st == CT_IDLE) && !cfg_mode && !cfg_flush;

    always_comb begin
        d         = q;
        d.rsp_v   = 1'b0;
        seq_start = 1'b0;
        c_retag   = 1'b0;
        c_flush   = 1'b0;
        case (q.st)
            CT_IDLE: begin
                c_flush = cfg_flush;
                if (req_valid && req_ready) begin
                    if (c_hit) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = c_rd_data;
                    end else begin
                        seq_start = 1'b1;
                        c_retag   = 1'b1;
                        d.st      = CT_FILL;
                        d.want    = req_idx;
                        d.widx    = req_idx;
                        d.pend    = 1'b0;
                    end
                end
            end
            default: begin
                d.pend = q.pend | cfg_flush;
                if (word_valid) begin
                    d.widx = q.widx + 1'b1;
                    if (q.widx == q.want)
                        d.rsp_d = word_data;
                end
                if (seq_done) begin
                    c_flush = q.pend | cfg_flush;
                    d.pend  = 1'b0;
                    d.rsp_v = 1'b1;
                    d.st    = CT_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= CT_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_data  = q.rsp_d;

    xip_line_cache #(
        .LINE_WORDS(LINE_WORDS),
        .TAG_W     (TAG_W)
    ) line_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (c_flush),
        .retag  (c_retag),
        .new_tag(req_tag),
        .wr_en  (word_valid),
        .wr_idx (q.widx),
        .wr_data(word_data),
        .rd_tag (req_tag),
        .rd_idx (req_idx),
        .hit    (c_hit),
        .rd_data(c_rd_data)
    );

    xip_serial_seq #(
        .WCW(CNT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .cmd       (cfg_cmd),
        .cmd_en    (cfg_cmd_en),
        .opt       (cfg_opt),
        .opt_en    (cfg_opt_en),
        .addr4     (cfg_addr_code >= 3'd3),
        .dummy     (cfg_dummy),
        .faddr     (faddr),
        .n_words   (n_words),
        .cs_n      (flash_cs_n),
        .sclk      (flash_sclk),
        .mosi      (flash_mosi),
        .miso      (flash_miso),
        .word_valid(word_valid),
        .word_data (word_data),
        .done      (seq_done)
    );

endmodule

// File: rtl/xip_read_engine_chk.sv
module xip_read_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_mode,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic flash_cs_n,
    input logic flash_sclk,
    input logic seq_done
);

    // R11: no serial clock outside a frame
    p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> !flash_sclk);

    // R11: chip select only rises when the sequencer closes the frame
    p_cs_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |-> seq_done);

    // R6: no acceptance while a frame is open
    p_stall_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> !req_ready);

    // R8: parked path accepts nothing
    p_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> !req_ready);

    // R4: a frame opens only right after an accepted request
    p_frame_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_cs_n) |-> $past(req_valid && req_ready));

    // R10: a response follows an acceptance (hit) or a finished fill
    p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(seq_done)));

endmodule

bind xip_read_engine xip_read_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .flash_cs_n(flash_cs_n),
    .flash_sclk(flash_sclk),
    .seq_done  (seq_done)
);

// File: tb/xip_read_engine_tb_top.sv
module xip_read_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0, cfg_flush = 1'b0;
    logic [7:0]  cfg_cmd = 8'h03, cfg_opt = 8'h00;
    logic        cfg_cmd_en = 1'b1, cfg_opt_en = 1'b0;
    logic [2:0]  cfg_addr_code = 3'd1;
    logic [4:0]  cfg_dummy = 5'd0, cfg_burst_m1 = 5'd0;
    logic [3:0]  cfg_ext = 4'd0;
    logic        cfg_burst_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_data;
    logic        flash_cs_n, flash_sclk, flash_mosi;
    logic        flash_miso = 1'b0;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xip_read_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_flush(cfg_flush),
        .cfg_cmd(cfg_cmd), .cfg_cmd_en(cfg_cmd_en), .cfg_opt(cfg_opt),
        .cfg_opt_en(cfg_opt_en), .cfg_addr_code(cfg_addr_code),
        .cfg_dummy(cfg_dummy), .cfg_ext(cfg_ext), .cfg_burst_m1(cfg_burst_m1),
        .cfg_burst_en(cfg_burst_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .flash_cs_n(flash_cs_n), .flash_sclk(flash_sclk), .flash_mosi(flash_mosi),
        .flash_miso(flash_miso)
    );

    // ---------------- flash model ----------------
    int          hlen = 32;
    int          abits = 24;
    int          bitc = 0;
    int          frames = 0;
    int          sclk_bad = 0;
    logic [95:0] hdr = '0;
    logic [31:0] rx_addr = '0;
    logic [7:0]  rx_cmd = '0, rx_opt = '0;

    function automatic logic [7:0] fbyte(logic [31:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ a[23:16] ^ {a[29:26], a[29:26]} ^ 8'hA5;
    endfunction

    always @(posedge flash_sclk or negedge flash_cs_n) begin
        if (flash_sclk) begin
            if (bitc < hlen)
                hdr = {hdr[94:0], flash_mosi};
            bitc++;
        end else begin
            bitc = 0;
            hdr  = '0;
            frames++;
        end
    end

    always @(posedge flash_sclk)
        if (flash_cs_n) sclk_bad++;

    always @(negedge flash_sclk) begin : flash_out
        logic [95:0] t;
        logic [7:0]  b;
        int          dbit;
        if (!flash_cs_n && bitc >= hlen) begin
            if (bitc == hlen) begin
                t       = hdr >> cfg_dummy;
                rx_addr = (abits == 32) ? t[31:0] : {8'h00, t[23:0]};
                t       = t >> abits;
                if (cfg_opt_en) begin
                    rx_opt = t[7:0];
                    t      = t >> 8;
                end
                if (cfg_cmd_en)
                    rx_cmd = t[7:0];
            end
            dbit       = bitc - hlen;
            b          = fbyte(rx_addr + 32'(dbit / 8));
            flash_miso = b[7 - (dbit % 8)];
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] exp_word(logic [25:0] off, logic [3:0] ext, bit a4);
        logic [31:0] base;
        logic [31:0] w;
        base = {2'b00, ext, off[25:2], 2'b00};
        if (!a4) base[31:24] = 8'h00;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = fbyte(base + 32'(i));
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input bit cen, input logic [7:0] c, input bit oen, input logic [7:0] o,
                           input logic [2:0] code, input logic [4:0] dm, input logic [3:0] ext,
                           input bit ben, input logic [4:0] m1);
        @(negedge clk);
        cfg_cmd_en = cen; cfg_cmd = c; cfg_opt_en = oen; cfg_opt = o;
        cfg_addr_code = code; cfg_dummy = dm; cfg_ext = ext;
        cfg_burst_en = ben; cfg_burst_m1 = m1;
        abits = (code >= 3'd3) ? 32 : 24;
        hlen  = (cen ? 8 : 0) + (oen ? 8 : 0) + abits + int'(dm);
    endtask

    task automatic flush_pulse();
        @(negedge clk); cfg_flush = 1'b1;
        @(negedge clk); cfg_flush = 1'b0;
    endtask

    task automatic do_read(input logic [25:0] a, output logic [31:0] data,
                           output int lat, output int nfr, output bit stalled);
        int f0;
        f0 = frames;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        stalled   = !req_ready;
        lat = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        data = rsp_data;
        nfr  = frames - f0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 response lasts one cycle", 32'(rsp_valid), 32'd0);
    endtask

    // ---------------- tests ----------------
    task automatic run_all();
        logic [31:0] d;
        int          lat, nfr, n;
        bit          st;
        int          m1s [5] = '{0, 1, 3, 7, 31};
        logic [25:0] off;
        logic [20:0] tag;

        repeat (4) @(negedge clk);
        chk(flash_cs_n == 1'b1, "R1 cs_n in reset", 32'(flash_cs_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flash_cs_n == 1'b1 && flash_sclk == 1'b0, "R1 bus idle after reset",
            {30'd0, flash_cs_n, flash_sclk}, 32'd2);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);

        // default 3-byte setup, single word
        set_cfg(1, 8'h0B, 0, 8'h00, 3'd1, 5'd8, 4'd6, 0, 5'd7);
        do_read(26'h0000104, d, lat, nfr, st);
        chk(nfr == 1, "R4 miss opens one frame", 32'(nfr), 32'd1);
        chk(st, "R6 ready low during fill", 32'(st), 32'd1);
        chk(rx_cmd == 8'h0B, "R2 command byte", 32'(rx_cmd), 32'h0B);
        chk(rx_addr == 32'h0000104, "R2 3-byte address", rx_addr, 32'h104);
        chk(d == exp_word(26'h104, 4'd6, 0), "R3 byte order", d, exp_word(26'h104, 4'd6, 0));
        do_read(26'h0000104, d, lat, nfr, st);
        chk(nfr == 0 && lat == 0, "R5 hit without frame", 32'(nfr * 256 + lat), 32'd0);
        do_read(26'h0000107, d, lat, nfr, st);
        chk(nfr == 0 && d == exp_word(26'h104, 4'd6, 0), "R9 byte offset ignored", d,
            exp_word(26'h104, 4'd6, 0));
        do_read(26'h0000108, d, lat, nfr, st);
        chk(nfr == 1, "R4 burst disabled fetches one word", 32'(nfr), 32'd1);

        // sweep burst lengths and start positions
        for (int k = 0; k < 5; k++) begin
            for (int s = 0; s < 8; s++) begin
                set_cfg(1, 8'hEB, 1, 8'h5A, 3'd3, 5'(k), 4'(k * 3 + s), 1, 5'(m1s[k]));
                flush_pulse();
                tag = 21'(k * 97 + s * 13 + 1);
                n   = (m1s[k] + 1 < 8 - s) ? m1s[k] + 1 : 8 - s;
                off = {tag, 3'(s), 2'b00};
                do_read(off, d, lat, nfr, st);
                chk(nfr == 1, "R4 sweep first read one frame", 32'(nfr), 32'd1);
                chk(d == exp_word(off, cfg_ext, 1), "R12 sweep data with upper bits", d,
                    exp_word(off, cfg_ext, 1));
                chk(rx_opt == 8'h5A && rx_cmd == 8'hEB, "R2 option and command", {rx_cmd, rx_opt},
                    32'hEB5A);
                for (int j = 1; j < n; j++) begin
                    off = {tag, 3'(s + j), 2'b00};
                    do_read(off, d, lat, nfr, st);
                    chk(nfr == 0 && lat == 0, "R5 burst word served from line", 32'(nfr), 32'd0);
                    chk(d == exp_word(off, cfg_ext, 1), "R3 burst word data", d,
                        exp_word(off, cfg_ext, 1));
                end
                if (s + n < 8) begin
                    off = {tag, 3'(s + n), 2'b00};
                    do_read(off, d, lat, nfr, st);
                    chk(nfr == 1, "R4 word past burst misses", 32'(nfr), 32'd1);
                    chk(d == exp_word(off, cfg_ext, 1), "R3 word past burst data", d,
                        exp_word(off, cfg_ext, 1));
                end
            end
        end

        // explicit upper address bits
        set_cfg(0, 8'h00, 0, 8'h00, 3'd4, 5'd2, 4'd3, 1, 5'd1);
        flush_pulse();
        do_read(26'h2ABCDE4, d, lat, nfr, st);
        chk(rx_addr[29:26] == 4'd3, "R12 upper bits ext=3", 32'(rx_addr[29:26]), 32'd3);
        set_cfg(0, 8'h00, 0, 8'h00, 3'd4, 5'd2, 4'd9, 1, 5'd1);
        flush_pulse();
        do_read(26'h2ABCDE4, d, lat, nfr, st);
        chk(rx_addr == {2'b00, 4'd9, 26'h2ABCDE4}, "R12 full address ext=9", rx_addr,
            {2'b00, 4'd9, 26'h2ABCDE4});
        chk(d == exp_word(26'h2ABCDE4, 4'd9, 1), "R12 data ext=9", d, exp_word(26'h2ABCDE4, 4'd9, 1));

        // flush while idle
        do_read(26'h2ABCDE4, d, lat, nfr, st);
        chk(nfr == 0, "R5 line holds word", 32'(nfr), 32'd0);
        flush_pulse();
        do_read(26'h2ABCDE4, d, lat, nfr, st);
        chk(nfr == 1, "R7 flush forces refetch", 32'(nfr), 32'd1);

        // flush during a fill
        flush_pulse();
        fork
            do_read(26'h0001230, d, lat, nfr, st);
            begin
                repeat (30) @(negedge clk);
                cfg_flush = 1'b1;
                @(negedge clk);
                cfg_flush = 1'b0;
            end
        join
        chk(d == exp_word(26'h0001230, 4'd9, 1), "R7 mid-fill flush still answers", d,
            exp_word(26'h0001230, 4'd9, 1));
        do_read(26'h0001230, d, lat, nfr, st);
        chk(nfr == 1, "R7 mid-fill flush invalidates line", 32'(nfr), 32'd1);

        // parked mode
        begin
            int f0, bad;
            f0  = frames;
            bad = 0;
            @(negedge clk);
            cfg_mode  = 1'b1;
            req_valid = 1'b1;
            req_addr  = 26'h0000040;
            repeat (30) begin
                @(negedge clk);
                if (req_ready || rsp_valid) bad++;
            end
            req_valid = 1'b0;
            @(negedge clk);
            chk(bad == 0, "R8 parked path accepts nothing", 32'(bad), 32'd0);
            chk(frames == f0, "R8 parked path opens no frame", 32'(frames - f0), 32'd0);
            cfg_mode = 1'b0;
            @(negedge clk);
            chk(req_ready == 1'b1, "R8 ready returns when unparked", 32'(req_ready), 32'd1);
        end

        chk(sclk_bad == 0, "R11 no clock outside frame", 32'(sclk_bad), 32'd0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (WD_CYCLES) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule